// File: doc/BRIEF.md
# Configuration address/data port decoder

This block sits behind a PC-style host bridge. It turns the two-port indirect scheme for configuration accesses into single requests to an array of configuration responders. Software first writes a 32-bit configuration address to the address port. It then reads or writes the data port with one, two or four bytes. Each data-port access is checked against the latched address. If it passes, it goes downstream as one request that carries the bus number, the device/function number, the byte offset and the access size.

The host side is a simple register-access bus. It has a request strobe, a write flag, a port select, four byte enables, lane-positioned write data and registered read data with an acknowledge. The responder side is a one-cycle request. The responder answers with a hit flag and right-aligned read data in the same cycle as the request. Every host access is acknowledged exactly two clock edges after it is accepted, whether or not it produced a downstream request.

Top module: `cfgx_port_bridge`

## Requirements
- R1: After reset the address register reads as zero, and `hst_ack`, `hst_rdata` and `dn_req` are all zero.
- R2: An address-port access (`hst_port`=0) with all four byte enables set writes or reads the whole 32-bit address register. An address-port write with any other enable pattern leaves the register unchanged. An address-port read with any other enable pattern returns 0xFF in each enabled lane and zero elsewhere.
- R3: When address bit 31 (the enable bit) is clear, a data-port access (`hst_port`=1) issues no downstream request. A read returns 0xFF in each enabled lane and zero elsewhere, and a write changes no configuration state.
- R4: When address bits 1:0 are not both zero, data-port accesses are ignored in the same way as in R3.
- R5: A forwarded access drives `dn_bus` = address[23:16] and `dn_devfn` = address[15:8], where devfn is the device number in bits 7:3 and the function number in bits 2:0. It drives `dn_offset` = {address[7:2], lane}, where lane is the index of the lowest enabled byte.
- R6: The valid data-port enable patterns are 0001, 0010, 0100 and 1000 (byte, `dn_size`=0), 0011, 0110 and 1100 (word, `dn_size`=1), and 1111 (dword, `dn_size`=2). Any other pattern is ignored as in R3, and a read with no enables returns zero.
- R7: On a forwarded write, `dn_wdata` holds the enabled host bytes shifted down so that the lowest enabled lane lands in bits 7:0. Bits above the access size are zero.
- R8: On a forwarded read that hits, responder byte i (bits 8i+7:8i) is returned in host lane lane+i, for each byte within the access size. All other lanes are zero.
- R9: A forwarded read with `dn_hit` low returns 0xFF in each enabled lane and zero elsewhere. A forwarded write to an absent function has no effect.
- R10: `dn_req` is high for the one cycle after the accepting clock edge. `hst_ack` is high for the one cycle after the following edge, once per accepted access. An address written in one cycle governs a data access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_port | input | 1 | Port offset: 0 = address port, 1 = data port |
| hst_be | input | 4 | Byte enables, lane i = bits 8i+7:8i |
| hst_wdata | input | 32 | Lane-positioned write data |
| hst_ack | output | 1 | Access complete, two edges after acceptance |
| hst_rdata | output | 32 | Lane-positioned read data, valid with `hst_ack` |
| dn_req | output | 1 | Downstream configuration request |
| dn_wr | output | 1 | Downstream write flag |
| dn_bus | output | 8 | Target bus number |
| dn_devfn | output | 8 | Device (7:3) and function (2:0) number |
| dn_offset | output | 8 | Byte offset within configuration space |
| dn_size | output | 2 | 0 byte, 1 word, 2 dword |
| dn_wdata | output | 32 | Right-aligned write data |
| dn_hit | input | 1 | Responder present, same cycle as `dn_req` |
| dn_rdata | input | 32 | Right-aligned responder read data |

## Verification
A corrupted address register affects the very next data access. A wrong bus, devfn or offset shows on the downstream fields one cycle after acceptance. A wrong gate shows as a request that is present or missing in that same cycle, and as an all-ones read one edge later. Lane or size errors show in `dn_wdata` one cycle after a write, or in `hst_rdata` at the acknowledge, as misplaced or unmasked bytes. A misrouted write stays hidden until a later readback of that function or of a neighbour, so the sweep reads back every function after the writes.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DW      = 32;
  localparam int LANES   = DW / 8;
  localparam int LW      = $clog2(LANES);
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int OFS_W   = 8;
  localparam int EN_BIT    = DW - 1;
  localparam int BUS_LSB   = 16;
  localparam int DEVFN_LSB = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  function automatic logic [DW-1:0] size_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE: size_mask = DW'(8'hFF);
      SZ_WORD: size_mask = DW'(16'hFFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_ones(logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfgp_be_decode.sv
module cfgp_be_decode
  import cfgp_pkg::*;
(
  input  logic [LANES-1:0] be,
  output logic             ok,
  output logic [LW-1:0]    lane,
  output acc_size_e        size
);
  always_comb begin
    ok   = 1'b1;
    lane = '0;
    size = SZ_BYTE;
    case (be)
      4'b0001: begin lane = 2'd0; size = SZ_BYTE;  end
      4'b0010: begin lane = 2'd1; size = SZ_BYTE;  end
      4'b0100: begin lane = 2'd2; size = SZ_BYTE;  end
      4'b1000: begin lane = 2'd3; size = SZ_BYTE;  end
      4'b0011: begin lane = 2'd0; size = SZ_WORD;  end
      4'b0110: begin lane = 2'd1; size = SZ_WORD;  end
      4'b1100: begin lane = 2'd2; size = SZ_WORD;  end
      4'b1111: begin lane = 2'd0; size = SZ_DWORD; end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfgp_lane_align.sv
module cfgp_lane_align
  import cfgp_pkg::*;
#(
  parameter bit TO_HOST = 1'b0
) (
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] lane,
  input  acc_size_e     size,
  output logic [DW-1:0] dout
);
  logic [LW+2:0] shamt;
  assign shamt = {lane, 3'b000};

  generate
    if (TO_HOST) begin : g_up
      assign dout = (din & size_mask(size)) << shamt;
    end else begin : g_down
      assign dout = (din >> shamt) & size_mask(size);
    end
  endgenerate
endmodule

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  // R2: only a qualifying full-width write may alter the latched address
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/cfgx_port_bridge.sv
module cfgx_port_bridge
  import cfgp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_req,
  input  logic               hst_wr,
  input  logic               hst_port,
  input  logic [LANES-1:0]   hst_be,
  input  logic [DW-1:0]      hst_wdata,
  output logic               hst_ack,
  output logic [DW-1:0]      hst_rdata,
  output logic               dn_req,
  output logic               dn_wr,
  output logic [BUS_W-1:0]   dn_bus,
  output logic [DEVFN_W-1:0] dn_devfn,
  output logic [OFS_W-1:0]   dn_offset,
  output logic [1:0]         dn_size,
  output logic [DW-1:0]      dn_wdata,
  input  logic               dn_hit,
  input  logic [DW-1:0]      dn_rdata
);
  logic [DW-1:0] areg;
  logic          areg_we;
  logic          full_be;
  logic          be_ok;
  logic [LW-1:0] be_lane;
  acc_size_e     be_size;
  logic          fwd;
  logic [DW-1:0] wr_aligned;
  logic [DW-1:0] rd_placed;

  // stage-1 state
  logic             s1_vld;
  logic             s1_wr;
  logic             s1_fwd;
  logic             s1_arq;
  logic [LANES-1:0] s1_be;
  logic [DW-1:0]    s1_aval;
  logic [LW-1:0]    s1_lane;
  acc_size_e        s1_size;

  assign full_be = &hst_be;
  assign areg_we = hst_req & ~hst_port & hst_wr & full_be;
  assign fwd     = hst_req & hst_port & be_ok & areg[EN_BIT] & (areg[1:0] == 2'b00);

  cfgp_addr_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .we    (areg_we),
    .wdata (hst_wdata),
    .q     (areg)
  );

  cfgp_be_decode u_bedec (
    .be   (hst_be),
    .ok   (be_ok),
    .lane (be_lane),
    .size (be_size)
  );

  cfgp_lane_align #(.TO_HOST(1'b0)) u_wr_align (
    .din  (hst_wdata),
    .lane (be_lane),
    .size (be_size),
    .dout (wr_aligned)
  );

  cfgp_lane_align #(.TO_HOST(1'b1)) u_rd_align (
    .din  (dn_rdata),
    .lane (s1_lane),
    .size (s1_size),
    .dout (rd_placed)
  );

  // stage 1: accept host access, launch downstream request
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_wr     <= 1'b0;
      s1_fwd    <= 1'b0;
      s1_arq    <= 1'b0;
      s1_be     <= '0;
      s1_aval   <= '0;
      s1_lane   <= '0;
      s1_size   <= SZ_BYTE;
      dn_req    <= 1'b0;
      dn_wr     <= 1'b0;
      dn_bus    <= '0;
      dn_devfn  <= '0;
      dn_offset <= '0;
      dn_size   <= '0;
      dn_wdata  <= '0;
    end else begin
      s1_vld  <= hst_req;
      s1_wr   <= hst_wr;
      s1_fwd  <= fwd;
      s1_arq  <= hst_req & ~hst_port & ~hst_wr & full_be;
      s1_be   <= hst_be;
      s1_aval <= areg;
      s1_lane <= be_lane;
      s1_size <= be_size;
      dn_req  <= fwd;
      if (fwd) begin
        dn_wr     <= hst_wr;
        dn_bus    <= areg[BUS_LSB +: BUS_W];
        dn_devfn  <= areg[DEVFN_LSB +: DEVFN_W];
        dn_offset <= {areg[OFS_W-1:2], be_lane};
        dn_size   <= be_size;
        dn_wdata  <= hst_wr ? wr_aligned : '0;
      end
    end
  end

  // stage 2: complete host access
  always_ff @(posedge clk) begin
    if (rst) begin
      hst_ack   <= 1'b0;
      hst_rdata <= '0;
    end else begin
      hst_ack <= s1_vld;
      if (!s1_vld || s1_wr)        hst_rdata <= '0;
      else if (s1_arq)             hst_rdata <= s1_aval;
      else if (s1_fwd && dn_hit)   hst_rdata <= rd_placed;
      else                         hst_rdata <= lane_ones(s1_be);
    end
  end

  // R3: a request only leaves when the enable bit was set at acceptance
  a_r3_enable: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> $past(areg[EN_BIT]));
  // R4: a request only leaves when the low address bits were zero
  a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> ($past(areg[1:0]) == 2'b00));
  // R5: routing follows the latched address
  a_r5_route: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_bus == $past(areg[BUS_LSB +: BUS_W]) &&
                dn_devfn == $past(areg[DEVFN_LSB +: DEVFN_W]) &&
                dn_offset[OFS_W-1:2] == $past(areg[OFS_W-1:2])));
  // R6: only legal size codes go downstream
  a_r6_size: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (dn_size != 2'd3));
  // R10: every downstream request is followed by a host acknowledge
  a_r10_ack: assert property (@(posedge clk) disable iff (rst)
    dn_req |=> hst_ack);
  // R8: returned data never occupies lanes the host did not enable
  a_r8_lanes: assert property (@(posedge clk) disable iff (rst)
    hst_ack |-> ((hst_rdata & ~lane_ones($past(s1_be))) == '0));
endmodule

// File: tb/cfgx_port_bridge_tb_top.sv
module cfgx_port_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_req = 1'b0, hst_wr = 1'b0, hst_port = 1'b0;
  logic [3:0]  hst_be = 4'h0;
  logic [31:0] hst_wdata = 32'h0;
  logic        hst_ack;
  logic [31:0] hst_rdata;
  logic        dn_req, dn_wr;
  logic [7:0]  dn_bus, dn_devfn, dn_offset;
  logic [1:0]  dn_size;
  logic [31:0] dn_wdata;
  logic        dn_hit;
  logic [31:0] dn_rdata;

  int nchk = 0, nfail = 0, dn_cnt = 0;
  bit done = 1'b0;
  logic [31:0] sh_areg = 32'h0;

  logic [7:0] rmem [4][256];
  logic [7:0] smem [4][256];

  logic        cap_req, cap_wr;
  logic [7:0]  cap_bus, cap_devfn, cap_ofs;
  logic [1:0]  cap_size;
  logic [31:0] cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_port_bridge dut_i (
    .clk(clk), .rst(rst), .hst_req(hst_req), .hst_wr(hst_wr), .hst_port(hst_port),
    .hst_be(hst_be), .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .dn_req(dn_req), .dn_wr(dn_wr), .dn_bus(dn_bus), .dn_devfn(dn_devfn),
    .dn_offset(dn_offset), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .dn_hit(dn_hit), .dn_rdata(dn_rdata)
  );

  function automatic logic [7:0] tbl_bus(int i);
    return (i == 3) ? 8'd2 : 8'd0;
  endfunction
  function automatic logic [7:0] tbl_devfn(int i);
    case (i)
      0: return 8'h00;
      1: return 8'h08;
      2: return 8'h0B;
      default: return 8'hF8;
    endcase
  endfunction
  function automatic int fn_index(logic [7:0] b, logic [7:0] df);
    for (int i = 0; i < 4; i++)
      if (tbl_bus(i) == b && tbl_devfn(i) == df) return i;
    return -1;
  endfunction

  // responder array
  always_comb begin
    int f;
    f = fn_index(dn_bus, dn_devfn);
    dn_hit = (f >= 0);
    dn_rdata = 32'hDEADBEEF;
    if (f >= 0)
      for (int i = 0; i < 4; i++) dn_rdata[8*i +: 8] = rmem[f][(int'(dn_offset) + i) & 255];
  end

  always @(posedge clk) begin
    if (rst) dn_cnt <= 0;
    else if (dn_req) begin
      dn_cnt <= dn_cnt + 1;
      if (dn_wr && fn_index(dn_bus, dn_devfn) >= 0)
        for (int i = 0; i < (1 << dn_size); i++)
          rmem[fn_index(dn_bus, dn_devfn)][(int'(dn_offset) + i) & 255] <= dn_wdata[8*i +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit be_valid(logic [3:0] be, output int lane, output int len);
    lane = 0; len = 0;
    for (int i = 3; i >= 0; i--) if (be[i]) lane = i;
    for (int i = 0; i < 4; i++) len += int'(be[i]);
    return (len == 1 || len == 2 || len == 4) && (int'(be) == (((1 << len) - 1) << lane));
  endfunction

  function automatic logic [31:0] ones(logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic host(input bit port, input bit wr, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    chk(hst_ack == 1'b0, "R10 ack idle", 32'(hst_ack), 32'h0);
    hst_req = 1'b1; hst_wr = wr; hst_port = port; hst_be = be; hst_wdata = wd;
    @(negedge clk);
    hst_req = 1'b0;
    cap_req = dn_req; cap_wr = dn_wr; cap_bus = dn_bus; cap_devfn = dn_devfn;
    cap_ofs = dn_offset; cap_size = dn_size; cap_wdata = dn_wdata;
    @(negedge clk);
    chk(hst_ack == 1'b1, "R10 ack", 32'(hst_ack), 32'h1);
    rd = hst_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    logic [31:0] rd;
    host(1'b0, 1'b1, 4'hF, a, rd);
    sh_areg = a;
  endtask

  function automatic bit exp_fwd(logic [3:0] be, output int lane, output int len);
    bit v;
    v = be_valid(be, lane, len);
    return v && sh_areg[31] && (sh_areg[1:0] == 2'b00);
  endfunction

  task automatic data_rd(input logic [3:0] be, input string tag);
    logic [31:0] rd, exp;
    int lane, len, f, base;
    bit fw;
    fw = exp_fwd(be, lane, len);
    f = fn_index(sh_areg[23:16], sh_areg[15:8]);
    base = int'(sh_areg[7:2]) * 4;
    host(1'b1, 1'b0, be, 32'h0, rd);
    exp = ones(be);
    if (fw && f >= 0) begin
      exp = 32'h0;
      for (int i = 0; i < len; i++) exp[8*(lane+i) +: 8] = smem[f][base + lane + i];
    end
    chk(rd == exp, tag, rd, exp);
    chk(cap_req == fw, {tag, " R3 R4 R6 forward"}, 32'(cap_req), 32'(fw));
    if (fw) begin
      chk({cap_bus, cap_devfn} == sh_areg[23:8], "R5 bus/devfn", {16'h0, cap_bus, cap_devfn}, {16'h0, sh_areg[23:8]});
      chk(int'(cap_ofs) == base + lane, "R5 offset", 32'(cap_ofs), 32'(base + lane));
      chk(cap_size == 2'($clog2(len)), "R6 size", 32'(cap_size), 32'($clog2(len)));
    end
  endtask

  task automatic data_wr(input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [31:0] rd, exp;
    int lane, len, f, base;
    bit fw;
    fw = exp_fwd(be, lane, len);
    f = fn_index(sh_areg[23:16], sh_areg[15:8]);
    base = int'(sh_areg[7:2]) * 4;
    host(1'b1, 1'b1, be, wd, rd);
    chk(cap_req == fw, {tag, " forward"}, 32'(cap_req), 32'(fw));
    if (fw) begin
      exp = 32'h0;
      for (int i = 0; i < len; i++) exp[8*i +: 8] = wd[8*(lane+i) +: 8];
      chk(cap_wdata == exp && cap_wr, "R7 write data", cap_wdata, exp);
      if (f >= 0)
        for (int i = 0; i < len; i++) smem[f][base + lane + i] = wd[8*(lane+i) +: 8];
    end
  endtask

  task automatic readback_all(input int r, input string tag);
    for (int f = 0; f < 4; f++) begin
      set_addr(32'h8000_0000 | (32'(tbl_bus(f)) << 16) | (32'(tbl_devfn(f)) << 8) | 32'(r << 2));
      data_rd(4'hF, tag);
    end
  endtask

  initial begin
    logic [31:0] rd;
    int c0;
    logic [3:0] vbe [8];
    vbe = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'hF};
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 256; o++) begin
        rmem[f][o] = 8'((f * 37 + o * 5 + 3) & 255);
        smem[f][o] = 8'((f * 37 + o * 5 + 3) & 255);
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(hst_ack == 0 && dn_req == 0 && hst_rdata == 0, "R1 reset outputs", hst_rdata, 32'h0);
    host(1'b0, 1'b0, 4'hF, 32'h0, rd);
    chk(rd == 32'h0, "R1 address reset value", rd, 32'h0);

    // R2 address port
    set_addr(32'h7F5A_C3A5);
    host(1'b0, 1'b0, 4'hF, 32'h0, rd);
    chk(rd == 32'h7F5A_C3A5, "R2 readback", rd, 32'h7F5A_C3A5);
    host(1'b0, 1'b1, 4'h1, 32'hFFFF_FFFF, rd);
    host(1'b0, 1'b1, 4'hC, 32'h0000_0000, rd);
    host(1'b0, 1'b0, 4'hF, 32'h0, rd);
    chk(rd == 32'h7F5A_C3A5, "R2 partial write ignored", rd, 32'h7F5A_C3A5);
    host(1'b0, 1'b0, 4'h3, 32'h0, rd);
    chk(rd == 32'h0000_FFFF, "R2 partial read", rd, 32'h0000_FFFF);

    // R5 R8 sweep over every present function, dword and legal pattern
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 64; r++) begin
        set_addr(32'h8000_0000 | (32'(tbl_bus(f)) << 16) | (32'(tbl_devfn(f)) << 8) | 32'(r << 2));
        for (int k = 0; k < 8; k++) data_rd(vbe[k], "R8 read sweep");
      end

    // R6 every enable pattern
    set_addr(32'h8000_0B20);
    for (int b = 0; b < 16; b++) data_rd(4'(b), "R6 pattern sweep");
    for (int b = 0; b < 16; b++) data_wr(4'(b), 32'h1000_0000 * b + 32'h00C3_5A00 + b, "R6 R7 write sweep");
    data_rd(4'hF, "R7 readback after sweep");

    // R7 writes with various widths
    set_addr(32'h8000_0810);
    data_wr(4'hF, 32'h1122_3344, "R7 dword write");
    data_wr(4'h6, 32'h00AA_BB00, "R7 word lane1");
    data_wr(4'h8, 32'hCC00_0000, "R7 byte lane3");
    data_rd(4'hF, "R7 readback");
    set_addr(32'h8002_F810);
    data_wr(4'hC, 32'h9876_0000, "R7 word lane2 dev31");
    readback_all(4, "R7 no crosstalk");

    // R9 absent function
    set_addr(32'h8000_1000);
    data_rd(4'hF, "R9 absent dword");
    data_rd(4'h2, "R9 absent byte");
    c0 = dn_cnt;
    data_wr(4'hF, 32'h5555_5555, "R9 absent write");
    chk(dn_cnt == c0 + 1, "R9 request issued", 32'(dn_cnt), 32'(c0 + 1));
    readback_all(0, "R9 absent write no effect");

    // R3 enable clear
    set_addr(32'h0000_0810);
    c0 = dn_cnt;
    data_wr(4'hF, 32'hA5A5_A5A5, "R3 disabled write");
    data_rd(4'hF, "R3 disabled read");
    data_rd(4'h4, "R3 disabled byte read");
    chk(dn_cnt == c0, "R3 no request", 32'(dn_cnt), 32'(c0));
    readback_all(4, "R3 dropped write no effect");

    // R4 low address bits
    for (int m = 1; m < 4; m++) begin
      set_addr(32'h8000_0810 | 32'(m));
      c0 = dn_cnt;
      data_wr(4'hF, 32'h0F0F_0F0F, "R4 misaligned write");
      data_rd(4'h3, "R4 misaligned read");
      chk(dn_cnt == c0, "R4 no request", 32'(dn_cnt), 32'(c0));
    end
    readback_all(4, "R4 dropped write no effect");

    // R10 back-to-back: address write then data read the next cycle
    sh_areg = 32'h8000_0B08;
    @(negedge clk);
    hst_req = 1'b1; hst_wr = 1'b1; hst_port = 1'b0; hst_be = 4'hF; hst_wdata = sh_areg;
    @(negedge clk);
    hst_wr = 1'b0; hst_port = 1'b1; hst_be = 4'hF;
    @(negedge clk);
    hst_req = 1'b0;
    chk(dn_req == 1'b1 && dn_devfn == 8'h0B && dn_offset == 8'h08, "R10 new address used", {24'h0, dn_offset}, 32'h08);
    chk(hst_ack == 1'b1 && hst_rdata == 32'h0, "R10 first ack", hst_rdata, 32'h0);
    @(negedge clk);
    rd = {smem[2][11], smem[2][10], smem[2][9], smem[2][8]};
    chk(hst_ack == 1'b1 && hst_rdata == rd, "R10 second ack", hst_rdata, rd);
    @(negedge clk);
    chk(hst_ack == 1'b0, "R10 single ack", 32'(hst_ack), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule